// File: doc/BRIEF.md
# Password Login and Access Checker

This block guards a tag memory of 34 words. Words 0 to 31 are writable storage. Word 0 holds the password, word 1 holds the protection word and word 2 holds the control word. Words 32 and 33 are read-only. The block keeps a sticky logged-in flag and gives an accept or refuse verdict on each request it is handed. A request is a login attempt, a password verification ahead of a password change, a word write, or a word read. For reads it also reports whether the word must be sent as all zeros.

The protection word and the control word are copied into internal registers only when `cfg_load` pulses. The surrounding logic raises that pulse at initialisation and on the Reset command. A write that lands in word 1 or word 2 therefore changes nothing here until the next load. The same pulse drops the login.

The protection word holds two inclusive address spans. Bits 7:0 and 15:8 give the first and last read-protected word. Bits 23:16 and 31:24 give the first and last write-inhibited word. Bit 16 of the control word turns on the password check for ordinary words. The serial front end reports two conditions on the request: whether parity was good and whether field power is sufficient for programming.

Top module: `pwd_access_gate`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `vrd_valid`, `vrd_ack`, `vrd_nak`, `vrd_masked` and `logged_in` are 0. The stored configuration is cleared to zero.
- R2: A login request (`req_kind` = 0) is accepted when `req_parity_ok` is 1 and `req_cand` equals `pw_word`. On acceptance `logged_in` is 1 from the verdict cycle on. Any other login attempt is refused and clears `logged_in`.
- R3: `logged_in` keeps its value across every request that is not a login. A `cfg_load` pulse clears it, and the clear wins over a login accepted in the same cycle.
- R4: A write request (`req_kind` = 2) to address 0, to 32 or 33, or to any address above 33 is always refused.
- R5: A write to address 1 or 2 is refused when the address lies inside the write-inhibit span, even when logged in. Otherwise it is accepted only when logged in.
- R6: A write to addresses 3 to 31 is refused inside the write-inhibit span. Otherwise it is accepted when control bit 16 is 0. When that bit is 1 it is accepted only when logged in.
- R7: Any write is refused when `req_power_ok` or `req_parity_ok` is 0.
- R8: A password verification request (`req_kind` = 1) is accepted only when parity is good, power is sufficient and `req_cand` equals `pw_word`. It never changes `logged_in`.
- R9: A read request (`req_kind` = 3) is accepted for addresses 0 to 33 and refused above. An accepted read sets `vrd_masked` when the address is 0, or when the address is inside the read-protect span and the block is not logged in.
- R10: An accepted read with `req_raw` = 1 (read-back after a write) is unmasked for every address except 0, whatever the read-protect span and login state.
- R11: The spans and the check bit come from `prot_word` and `ctrl_word` as sampled at the last `cfg_load`. Changes on those inputs between loads have no effect on verdicts.
- R12: A span covers first <= address <= last, both ends included. A span with first > last covers no address.
- R13: Every request cycle is followed one cycle later by a single-cycle `vrd_valid` with exactly one of `vrd_ack` and `vrd_nak` set. With no request, all verdict outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Latch protection and control words and drop the login |
| pw_word | input | 32 | Stored password |
| ctrl_word | input | 32 | Stored control word (bit 16 check enable) |
| prot_word | input | 32 | Stored protection word (two 16-bit spans) |
| req_valid | input | 1 | Request strobe, one cycle |
| req_kind | input | 2 | 0 login, 1 password verify, 2 write, 3 read |
| req_addr | input | 6 | Target word address |
| req_cand | input | 32 | Received password candidate |
| req_parity_ok | input | 1 | Received frame had good parity |
| req_power_ok | input | 1 | Field power sufficient for programming |
| req_raw | input | 1 | Read is a read-back of the word just written |
| vrd_valid | output | 1 | Verdict strobe |
| vrd_ack | output | 1 | Request accepted |
| vrd_nak | output | 1 | Request refused |
| vrd_masked | output | 1 | Read data must be sent as zeros |
| logged_in | output | 1 | Login flag |

## Verification
For each of four configurations, the bench sweeps all 64 addresses, both logged-out and logged-in, with writes under every pairing of parity and power and reads with and without read-back. The configurations are chosen so that spans end exactly on neighbouring addresses, one span is empty (first > last), one span covers addresses 1 and 2, and the check bit is both set and clear. A run of this kind separates write inhibit from login rules, and inclusive bounds from exclusive ones. Login and verification are tried with matching and single-bit-off candidates and with bad parity, which separates the sticky flag from the verdict. The inputs are changed without a load pulse to show that the latched configuration alone decides.

// File: rtl/pag_pkg.sv
package pag_pkg;

    localparam int FIELD_W = 8;

    typedef enum logic [1:0] {
        REQ_LOGIN = 2'd0,
        REQ_PWCHK = 2'd1,
        REQ_WRITE = 2'd2,
        REQ_READ  = 2'd3
    } req_kind_e;

    // Packed so that the low field lands at the low bits of a 16-bit slice
    typedef struct packed {
        logic [FIELD_W-1:0] last;
        logic [FIELD_W-1:0] first;
    } span_t;

    typedef struct packed {
        logic vld;
        logic ack;
        logic nak;
        logic masked;
    } verdict_t;

    function automatic logic span_hit(input logic [FIELD_W-1:0] a, input span_t s);
        return (a >= s.first) && (a <= s.last);
    endfunction

endpackage

// File: rtl/pag_cfg_regs.sv
module pag_cfg_regs
    import pag_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int CHK_BIT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] ctrl_in,
    input  logic [WORD_W-1:0] prot_in,
    output logic              chk_en,
    output span_t             spans [2]
);
    localparam int SPAN_W = 2 * FIELD_W;

    logic              chk_q;
    logic [WORD_W-1:0] prot_q;
    logic              ctrl_unused;

    assign ctrl_unused = ^{ctrl_in[WORD_W-1:CHK_BIT+1], ctrl_in[CHK_BIT-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_q  <= 1'b0;
            prot_q <= '0;
        end else if (load) begin
            chk_q  <= ctrl_in[CHK_BIT];
            prot_q <= prot_in;
        end
    end

    assign chk_en = chk_q;

    // spans[0]: read protect, spans[1]: write inhibit
    for (genvar i = 0; i < 2; i++) begin : g_span
        assign spans[i] = span_t'(prot_q[i*SPAN_W +: SPAN_W]);
    end

endmodule

// File: rtl/pag_login_flag.sv
module pag_login_flag (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic upd,
    input  logic val,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            flag <= 1'b0;
        end else if (upd) begin
            flag <= val;
        end
    end
endmodule

// File: rtl/pag_decide.sv
module pag_decide
    import pag_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int ADDR_W    = 6,
    parameter int NUM_EE    = 32,
    parameter int NUM_ROM   = 2,
    parameter int CFG_FIRST = 1,
    parameter int CFG_LAST  = 2
) (
    input  req_kind_e         kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] cand,
    input  logic [WORD_W-1:0] pw,
    input  logic              chk_en,
    input  span_t             spans [2],
    input  logic              logged,
    input  logic              parity_ok,
    input  logic              power_ok,
    input  logic              raw,
    output logic              ack,
    output logic              nak,
    output logic              masked,
    output logic              login_upd,
    output logic              login_val
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_EE + NUM_ROM - 1);
    localparam logic [ADDR_W-1:0] FIRST_ROM = ADDR_W'(NUM_EE);
    localparam logic [ADDR_W-1:0] CFG_LO    = ADDR_W'(CFG_FIRST);
    localparam logic [ADDR_W-1:0] CFG_HI    = ADDR_W'(CFG_LAST);

    logic [FIELD_W-1:0] addr_x;
    logic               pw_match, in_map, rp_hit, wi_hit, is_cfg, write_ok;

    assign addr_x   = FIELD_W'(addr);
    assign pw_match = (cand == pw);
    assign in_map   = (addr <= LAST_ADDR);
    assign rp_hit   = span_hit(addr_x, spans[0]);
    assign wi_hit   = span_hit(addr_x, spans[1]);
    assign is_cfg   = (addr >= CFG_LO) && (addr <= CFG_HI);

    always_comb begin
        write_ok = 1'b0;
        if (parity_ok && power_ok && addr != '0 && addr < FIRST_ROM && !wi_hit) begin
            if (is_cfg) write_ok = logged;
            else        write_ok = !chk_en || logged;
        end
    end

    always_comb begin
        ack       = 1'b0;
        masked    = 1'b0;
        login_upd = 1'b0;
        login_val = 1'b0;
        unique case (kind)
            REQ_LOGIN: begin
                ack       = parity_ok && pw_match;
                login_upd = 1'b1;
                login_val = parity_ok && pw_match;
            end
            REQ_PWCHK: ack = parity_ok && power_ok && pw_match;
            REQ_WRITE: ack = write_ok;
            REQ_READ: begin
                ack    = in_map;
                masked = in_map && ((addr == '0) || (rp_hit && !logged && !raw));
            end
            default: ack = 1'b0;
        endcase
        nak = !ack;
    end

endmodule

// File: rtl/pwd_access_gate.sv
module pwd_access_gate
    import pag_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int ADDR_W    = 6,
    parameter int NUM_EE    = 32,
    parameter int NUM_ROM   = 2,
    parameter int CHK_BIT   = 16,
    parameter int CFG_FIRST = 1,
    parameter int CFG_LAST  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_load,
    input  logic [WORD_W-1:0] pw_word,
    input  logic [WORD_W-1:0] ctrl_word,
    input  logic [WORD_W-1:0] prot_word,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_cand,
    input  logic              req_parity_ok,
    input  logic              req_power_ok,
    input  logic              req_raw,
    output logic              vrd_valid,
    output logic              vrd_ack,
    output logic              vrd_nak,
    output logic              vrd_masked,
    output logic              logged_in
);
    logic      chk_en;
    span_t     spans [2];
    logic      d_ack, d_nak, d_masked, d_upd, d_val;
    verdict_t  v_q;

    pag_cfg_regs #(.WORD_W(WORD_W), .CHK_BIT(CHK_BIT)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .load    (cfg_load),
        .ctrl_in (ctrl_word),
        .prot_in (prot_word),
        .chk_en  (chk_en),
        .spans   (spans)
    );

    pag_decide #(
        .WORD_W(WORD_W), .ADDR_W(ADDR_W), .NUM_EE(NUM_EE), .NUM_ROM(NUM_ROM),
        .CFG_FIRST(CFG_FIRST), .CFG_LAST(CFG_LAST)
    ) u_dec (
        .kind      (req_kind_e'(req_kind)),
        .addr      (req_addr),
        .cand      (req_cand),
        .pw        (pw_word),
        .chk_en    (chk_en),
        .spans     (spans),
        .logged    (logged_in),
        .parity_ok (req_parity_ok),
        .power_ok  (req_power_ok),
        .raw       (req_raw),
        .ack       (d_ack),
        .nak       (d_nak),
        .masked    (d_masked),
        .login_upd (d_upd),
        .login_val (d_val)
    );

    pag_login_flag u_login (
        .clk  (clk),
        .rst  (rst),
        .clr  (cfg_load),
        .upd  (req_valid && d_upd),
        .val  (d_val),
        .flag (logged_in)
    );

    always_ff @(posedge clk) begin
        if (rst || !req_valid) begin
            v_q <= '0;
        end else begin
            v_q <= '{vld: 1'b1, ack: d_ack, nak: d_nak, masked: d_masked};
        end
    end

    assign vrd_valid  = v_q.vld;
    assign vrd_ack    = v_q.ack;
    assign vrd_nak    = v_q.nak;
    assign vrd_masked = v_q.masked;

endmodule

// File: rtl/pag_checker.sv
module pag_checker
    import pag_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_load,
    input logic              req_valid,
    input logic [1:0]        req_kind,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_power_ok,
    input logic              vrd_valid,
    input logic              vrd_ack,
    input logic              vrd_nak,
    input logic              vrd_masked,
    input logic              logged_in
);
    // R13
    verdict_follows_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> vrd_valid);

    // R13
    quiet_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!vrd_valid && !vrd_ack && !vrd_nak && !vrd_masked));

    // R3
    login_drop_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_load |=> !logged_in);

    // R2
    login_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(logged_in) |-> $past(req_valid && req_kind == REQ_LOGIN));

    // R4
    pw_slot_write_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == REQ_WRITE && req_addr == '0) |=> vrd_nak);

    // R7
    low_power_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == REQ_WRITE && !req_power_ok) |=> vrd_nak);

    // R9
    pw_read_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == REQ_READ && req_addr == '0) |=> vrd_masked);

    // R8
    pwchk_keeps_login_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == REQ_PWCHK && !cfg_load) |=> $stable(logged_in));

endmodule

bind pwd_access_gate pag_checker #(.ADDR_W(ADDR_W)) u_pag_checker (
    .clk          (clk),
    .rst          (rst),
    .cfg_load     (cfg_load),
    .req_valid    (req_valid),
    .req_kind     (req_kind),
    .req_addr     (req_addr),
    .req_power_ok (req_power_ok),
    .vrd_valid    (vrd_valid),
    .vrd_ack      (vrd_ack),
    .vrd_nak      (vrd_nak),
    .vrd_masked   (vrd_masked),
    .logged_in    (logged_in)
);

// File: tb/pwd_access_gate_bench.sv
module pwd_access_gate_bench;
    localparam logic [31:0] PW = 32'hC0DE_1234;

    logic        clk = 1'b0;
    logic        rst, cfg_load;
    logic [31:0] pw_word, ctrl_word, prot_word, req_cand;
    logic        req_valid, req_parity_ok, req_power_ok, req_raw;
    logic [1:0]  req_kind;
    logic [5:0]  req_addr;
    logic        vrd_valid, vrd_ack, vrd_nak, vrd_masked, logged_in;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 0;
    logic mdl_logged;
    logic [31:0] ld_ctrl, ld_prot;

    always #2.5 clk = ~clk;

    pwd_access_gate u_pwd_access_gate (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .pw_word(pw_word),
        .ctrl_word(ctrl_word), .prot_word(prot_word), .req_valid(req_valid),
        .req_kind(req_kind), .req_addr(req_addr), .req_cand(req_cand),
        .req_parity_ok(req_parity_ok), .req_power_ok(req_power_ok), .req_raw(req_raw),
        .vrd_valid(vrd_valid), .vrd_ack(vrd_ack), .vrd_nak(vrd_nak),
        .vrd_masked(vrd_masked), .logged_in(logged_in)
    );

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    function automatic bit inside_span(input int a, input logic [7:0] f, input logic [7:0] l);
        return (a >= int'(f)) && (a <= int'(l));
    endfunction

    // expected {ack, masked}, built from the requirement text
    function automatic logic [1:0] model(input int kind, input int a, input bit match,
                                         input bit par, input bit pwr, input bit raw, input bit lg);
        bit rp, wi;
        rp = inside_span(a, ld_prot[7:0], ld_prot[15:8]);
        wi = inside_span(a, ld_prot[23:16], ld_prot[31:24]);
        case (kind)
            0: return {par && match, 1'b0};
            1: return {par && pwr && match, 1'b0};
            2: begin
                if (!par || !pwr || a == 0 || a >= 32 || wi) return 2'b00;
                if (a <= 2) return {lg, 1'b0};
                return {ld_ctrl[16] ? lg : 1'b1, 1'b0};
            end
            default: begin
                if (a > 33) return 2'b00;
                return {1'b1, (a == 0) || (rp && !lg && !raw)};
            end
        endcase
    endfunction

    function automatic string tag_of(input int kind, input int a, input bit par, input bit pwr, input bit raw);
        if (kind == 0) return "R2";
        if (kind == 1) return "R8";
        if (kind == 2) begin
            if (a == 0 || a >= 32) return "R4";
            if (!par || !pwr) return "R7";
            if (a <= 2) return "R5";
            return "R6";
        end
        return raw ? "R10" : "R9";
    endfunction

    task automatic load_cfg(input logic [31:0] c, input logic [31:0] p);
        @(negedge clk);
        ctrl_word = c; prot_word = p; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        ld_ctrl = c; ld_prot = p; mdl_logged = 1'b0;
        check("R3", "login after load", logged_in, 1'b0);
    endtask

    task automatic do_req(input int kind, input int a, input logic [31:0] cand,
                          input bit par, input bit pwr, input bit raw);
        logic [1:0] e;
        string      t;
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'(kind); req_addr = 6'(a); req_cand = cand;
        req_parity_ok = par; req_power_ok = pwr; req_raw = raw;
        e = model(kind, a, cand == PW, par, pwr, raw, mdl_logged);
        t = tag_of(kind, a, par, pwr, raw);
        @(negedge clk);
        req_valid = 1'b0;
        check("R13", "valid", vrd_valid, 1'b1);
        check(t, $sformatf("ack kind %0d addr %0d", kind, a), vrd_ack, e[1]);
        check("R13", "nak", vrd_nak, !e[1]);
        check(t, $sformatf("masked kind %0d addr %0d", kind, a), vrd_masked, e[0]);
        if (kind == 0) mdl_logged = e[1];
        check(kind == 0 ? "R2" : "R3", "logged_in", logged_in, mdl_logged);
    endtask

    task automatic sweep();
        for (int a = 0; a < 64; a++) begin
            do_req(2, a, 32'h0, 1, 1, 0);
            do_req(2, a, 32'h0, 0, 1, 0);
            do_req(2, a, 32'h0, 1, 0, 0);
            do_req(3, a, 32'h0, 1, 1, 0);
            do_req(3, a, 32'h0, 1, 1, 1);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R13 watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        logic [31:0] cfg_c [4];
        logic [31:0] cfg_p [4];
        // protection = {wi_last, wi_first, rp_last, rp_first}
        cfg_c[0] = 32'h0002_0100; cfg_p[0] = {8'd14, 8'd2,  8'd9,  8'd5};
        cfg_c[1] = 32'h0001_0000; cfg_p[1] = {8'd31, 8'd31, 8'd10, 8'd20};   // R12 empty read span
        cfg_c[2] = 32'h0001_0000; cfg_p[2] = {8'd3,  8'd40, 8'd33, 8'd0};    // R12 empty write span
        cfg_c[3] = 32'hFFFE_FFFF; cfg_p[3] = {8'd1,  8'd1,  8'd33, 8'd33};

        rst = 1'b1; cfg_load = 1'b0; req_valid = 1'b0; req_kind = 2'd0; req_addr = '0;
        req_cand = '0; req_parity_ok = 1'b0; req_power_ok = 1'b0; req_raw = 1'b0;
        pw_word = PW; ctrl_word = '0; prot_word = '0; mdl_logged = 1'b0;
        ld_ctrl = '0; ld_prot = '0;
        repeat (3) @(negedge clk);
        check("R1", "valid in reset", vrd_valid, 1'b0);
        check("R1", "ack in reset", vrd_ack, 1'b0);
        check("R1", "nak in reset", vrd_nak, 1'b0);
        check("R1", "masked in reset", vrd_masked, 1'b0);
        check("R1", "login in reset", logged_in, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "valid after reset", vrd_valid, 1'b0);
        check("R1", "login after reset", logged_in, 1'b0);
        // cleared configuration: both spans are [0,0], check bit off
        do_req(2, 5, 32'h0, 1, 1, 0);
        do_req(3, 0, 32'h0, 1, 1, 0);

        for (int c = 0; c < 4; c++) begin
            load_cfg(cfg_c[c], cfg_p[c]);
            sweep();
            do_req(1, 0, PW, 1, 1, 0);
            do_req(0, 0, PW ^ 32'h1, 1, 1, 0);
            do_req(0, 0, PW, 1, 1, 0);
            sweep();
            do_req(1, 0, PW ^ 32'h8000_0000, 1, 1, 0);
            do_req(1, 0, PW, 1, 0, 0);
            do_req(1, 0, PW, 1, 1, 0);
            check("R3", "login kept after sweep", logged_in, 1'b1);
            @(negedge clk);
            check("R13", "idle no verdict", vrd_valid, 1'b0);
            do_req(0, 0, PW, 0, 1, 0);
            do_req(0, 0, PW, 1, 1, 0);
        end

        // R11: input change without load pulse has no effect
        load_cfg(cfg_c[0], cfg_p[0]);
        prot_word = cfg_p[2]; ctrl_word = cfg_c[2];
        do_req(3, 20, 32'h0, 1, 1, 0);
        check("R11", "unloaded span ignored", vrd_masked, 1'b0);
        do_req(2, 20, 32'h0, 1, 1, 0);
        check("R11", "unloaded check bit ignored", vrd_ack, 1'b1);
        load_cfg(cfg_c[2], cfg_p[2]);
        do_req(3, 20, 32'h0, 1, 1, 0);
        check("R11", "loaded span applies", vrd_masked, 1'b1);

        // R3: load in the same cycle as a good login clears the flag
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd0; req_cand = PW; req_parity_ok = 1'b1; cfg_load = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; cfg_load = 1'b0;
        check("R3", "load beats login", logged_in, 1'b0);

        done = 1;
        finish_run();
    end
endmodule